// File: doc/BRIEF.md
# Multi-Window Address Translator

This block turns an incoming request address into a translated address using a small set of programmable windows. Each window is described by a base page, a translation page and an attribute word. The attribute word carries an enable bit and a power-of-two size exponent. A request that lands inside an enabled window leaves the block with its offset from the window base added to the window's target address. A request that lands in no window passes through unchanged.

The same module serves both traffic directions. An outbound instance, from the processor towards the bus, uses four windows. An inbound instance, from the bus towards local memory, uses three windows. It also turns on a fixed direct-mapped bus-memory region, and that region takes precedence over every window.

Window registers are written and read through a simple one-cycle configuration port. Lookups are accepted every cycle, and each result appears on registered outputs one cycle after its request.

Top module: `xlat_top`

## Requirements
- R1: A request presented with `reqValid` high produces `rspValid` high on the following cycle. A cycle without a request produces `rspValid` low on the following cycle. Reset clears `rspValid`, `rspHit`, `rspBypass`, `rspWin` and `rspAddr` to zero.
- R2: A window takes part in matching only while bit 31 of its attribute register is 1. With that bit at 0, the window never matches, whatever its base and size.
- R3: A window covers the addresses from its base up to, but not including, base plus (2 << attribute[5:0]). An exponent of 63 covers the entire 64-bit address space, with no wrap of the limit.
- R4: The window base is the base register shifted left by 12, and the target is the translation register shifted left by 12. A hit returns target + (address − base), modulo 2^64.
- R5: When several enabled windows contain the address, the window with the lowest index is used. `rspWin` reports that index.
- R6: A miss returns `rspHit` = 0 and `rspWin` = 0, with `rspAddr` equal to the request address.
- R7: When the bypass region is enabled by parameter, an address inside it returns `rspBypass` = 1 and `rspHit` = 0, with the address unchanged, even if a window also contains it.
- R8: Register selectors on `cfgSel` are 0 translation, 1 extended translation, 2 base, 3 extended base and 4 attribute. A write is visible on `cfgRdata` from the next cycle. Selectors 5 to 7 store nothing and read as 0.
- R9: The extended translation and extended base registers are stored, but they have no effect on matching or on the translated address.
- R10: Attribute bits other than bit 31 and bits [5:0] are stored as written, including the prefetch flag (bit 29), the target code (bits 23:20) and the snoop codes (bits 19:12). They do not change matching or translation.
- R11: A configuration write in the same cycle as a request does not affect that request. It applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWin | input | WIN_W | Window index for write and read |
| cfgSel | input | 3 | Register selector within the window |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Combinational read of the selected register |
| reqValid | input | 1 | Lookup request valid |
| reqAddr | input | ADDR_W | Address to translate |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspHit | output | 1 | An enabled window matched |
| rspBypass | output | 1 | Address fell in the direct-mapped region |
| rspWin | output | WIN_W | Index of the matching window |
| rspAddr | output | ADDR_W | Translated or passed-through address |

## Verification
The hardest situation to reach is a configuration write that lands in the same clock edge as a lookup it would change. The stimulus drives both in one cycle: it disables a window and requests an address inside that window. It then checks that the first result still uses the old setting and that a second request falls through to another window. The overflow corner needs a whole-space window (exponent 63) reached by an address near 2^64, with the translated sum wrapping. The bench also places that address alongside the bypass region and alongside overlapping lower-numbered windows, so the priority order can be seen at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int REG_W      = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int EN_BIT     = 31;
  localparam int SZ_W       = 6;

  typedef enum logic [2:0] {
    SEL_XLAT     = 3'd0,
    SEL_XLAT_EXT = 3'd1,
    SEL_BASE     = 3'd2,
    SEL_BASE_EXT = 3'd3,
    SEL_ATTR     = 3'd4
  } cfgSel_e;

  typedef struct packed {
    logic [REG_W-1:0] xlat;
    logic [REG_W-1:0] xlatExt;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] baseExt;
    logic [REG_W-1:0] attr;
  } winCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic idle;
  } stb_t;
endpackage

// File: rtl/xlat_win_match.sv
module xlat_win_match
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  winCfg_t           cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              match,
  output logic [ADDR_W-1:0] xlatAddr
);
  localparam int EXT_W = ADDR_W + 1;
  localparam int PAD_W = EXT_W - REG_W - PAGE_SHIFT;

  logic [EXT_W-1:0] baseFull;
  logic [EXT_W-1:0] tgtFull;
  logic [EXT_W-1:0] addrFull;
  logic [EXT_W-1:0] offset;
  logic [EXT_W-1:0] winSize;
  logic [SZ_W-1:0]  sizeExp;
  logic             geBase;
  logic             wholeSpace;
  logic             inRange;

  always_comb begin
    sizeExp    = cfg.attr[SZ_W-1:0];
    baseFull   = {{PAD_W{1'b0}}, cfg.base, {PAGE_SHIFT{1'b0}}};
    tgtFull    = {{PAD_W{1'b0}}, cfg.xlat, {PAGE_SHIFT{1'b0}}};
    addrFull   = {1'b0, addr};
    geBase     = addrFull >= baseFull;
    offset     = addrFull - baseFull;
    // limit held in one extra bit so the largest exponent cannot wrap
    winSize    = EXT_W'(2) << sizeExp;
    wholeSpace = (int'(sizeExp) >= ADDR_W - 1);
    inRange    = geBase && (wholeSpace || (offset < winSize));
    match      = cfg.attr[EN_BIT] && inRange;
    xlatAddr   = tgtFull[ADDR_W-1:0] + offset[ADDR_W-1:0];
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfgWe,
  input  logic [WIN_W-1:0]        cfgWin,
  input  logic [2:0]              cfgSel,
  input  logic [REG_W-1:0]        cfgWdata,
  output logic [REG_W-1:0]        cfgRdata,
  input  logic                    reqValid,
  output winCfg_t [NUM_WIN-1:0]   winCfg,
  output stb_t                    stb
);
  genvar g;
  generate
    for (g = 0; g < NUM_WIN; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          winCfg[g] <= '0;
        end else if (cfgWe && (cfgWin == WIN_W'(g))) begin
          case (cfgSel)
            SEL_XLAT:     winCfg[g].xlat    <= cfgWdata;
            SEL_XLAT_EXT: winCfg[g].xlatExt <= cfgWdata;
            SEL_BASE:     winCfg[g].base    <= cfgWdata;
            SEL_BASE_EXT: winCfg[g].baseExt <= cfgWdata;
            SEL_ATTR:     winCfg[g].attr    <= cfgWdata;
            default: ;
          endcase
        end
      end
    end
  endgenerate

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (cfgWin == WIN_W'(i)) begin
        case (cfgSel)
          SEL_XLAT:     cfgRdata = winCfg[i].xlat;
          SEL_XLAT_EXT: cfgRdata = winCfg[i].xlatExt;
          SEL_BASE:     cfgRdata = winCfg[i].base;
          SEL_BASE_EXT: cfgRdata = winCfg[i].baseExt;
          SEL_ATTR:     cfgRdata = winCfg[i].attr;
          default:      cfgRdata = '0;
        endcase
      end
    end
  end

  always_comb begin
    stb.capture = reqValid;
    stb.idle    = !reqValid;
  end

  // R8: a legal write is readable next cycle while the selection is held
  p_cfg_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWe && (32'(cfgWin) < NUM_WIN) && (cfgSel <= 3'd4)) |=>
      (($past(cfgWin) != cfgWin) || ($past(cfgSel) != cfgSel) ||
       (cfgRdata == $past(cfgWdata))));

  // R8: unused selectors read as zero
  p_sel_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgSel > 3'd4) |-> (cfgRdata == '0));
endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int          NUM_WIN     = 4,
  parameter int          WIN_W       = 2,
  parameter int          ADDR_W      = 64,
  parameter bit          BYPASS_EN   = 1'b0,
  parameter logic [63:0] BYPASS_BASE = 64'h0,
  parameter int          BYPASS_LOG2 = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  winCfg_t [NUM_WIN-1:0] winCfg,
  input  stb_t                  stb,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic                  rspBypass,
  output logic [WIN_W-1:0]      rspWin,
  output logic [ADDR_W-1:0]     rspAddr
);
  logic [NUM_WIN-1:0] matchVec;
  logic [ADDR_W-1:0]  xlatArr [NUM_WIN];
  logic [NUM_WIN-1:0] grantVec;
  logic               anyHit;
  logic [WIN_W-1:0]   pickIdx;
  logic [ADDR_W-1:0]  pickAddr;
  logic               inBypass;
  logic               useWin;

  genvar g;
  generate
    for (g = 0; g < NUM_WIN; g++) begin : g_win
      xlat_win_match #(.ADDR_W(ADDR_W)) u_match (
        .cfg      (winCfg[g]),
        .addr     (reqAddr),
        .match    (matchVec[g]),
        .xlatAddr (xlatArr[g])
      );
    end

    if (BYPASS_EN) begin : g_bypass
      localparam logic [ADDR_W-1:0] BP_BASE = ADDR_W'(BYPASS_BASE);
      always_comb inBypass = ((reqAddr >> BYPASS_LOG2) == (BP_BASE >> BYPASS_LOG2));
    end else begin : g_nobypass
      always_comb inBypass = 1'b0;
    end
  endgenerate

  // lowest index wins
  always_comb begin
    anyHit   = 1'b0;
    grantVec = '0;
    pickIdx  = '0;
    pickAddr = reqAddr;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (matchVec[i] && !anyHit) begin
        anyHit      = 1'b1;
        grantVec[i] = 1'b1;
        pickIdx     = WIN_W'(i);
        pickAddr    = xlatArr[i];
      end
    end
    useWin = anyHit && !inBypass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspBypass <= 1'b0;
      rspWin    <= '0;
      rspAddr   <= '0;
    end else if (stb.capture) begin
      rspValid  <= 1'b1;
      rspHit    <= useWin;
      rspBypass <= inBypass;
      rspWin    <= useWin ? pickIdx : '0;
      rspAddr   <= useWin ? pickAddr : reqAddr;
    end else if (stb.idle) begin
      rspValid  <= 1'b0;
    end
  end

  p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  p_miss_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspHit) |-> (rspAddr == $past(reqAddr) && rspWin == '0));
  p_bypass_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspBypass) |-> (!rspHit && rspAddr == $past(reqAddr)));
  p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec));

  generate
    for (g = 0; g < NUM_WIN; g++) begin : g_chk
      p_grant_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grantVec[g] |-> winCfg[g].attr[EN_BIT]);
      p_grant_reported_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reqValid && grantVec[g] && !inBypass) |=> (rspHit && rspWin == WIN_W'(g)));
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (winCfg[g].attr[EN_BIT] && winCfg[g].attr[SZ_W-1:0] == '1 &&
         winCfg[g].base == '0) |-> matchVec[g]);
    end
  endgenerate
endmodule

// File: rtl/xlat_top.sv
module xlat_top
  import xlat_pkg::*;
#(
  parameter int          NUM_WIN     = 4,
  parameter int          ADDR_W      = 64,
  parameter bit          BYPASS_EN   = 1'b0,
  parameter logic [63:0] BYPASS_BASE = 64'h0,
  parameter int          BYPASS_LOG2 = 32,
  parameter int          WIN_W       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [WIN_W-1:0]  cfgWin,
  input  logic [2:0]        cfgSel,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspBypass,
  output logic [WIN_W-1:0]  rspWin,
  output logic [ADDR_W-1:0] rspAddr
);
  winCfg_t [NUM_WIN-1:0] winCfg;
  stb_t                  stb;

  xlat_ctrl #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWe    (cfgWe),
    .cfgWin   (cfgWin),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .reqValid (reqValid),
    .winCfg   (winCfg),
    .stb      (stb)
  );

  xlat_dpath #(
    .NUM_WIN     (NUM_WIN),
    .WIN_W       (WIN_W),
    .ADDR_W      (ADDR_W),
    .BYPASS_EN   (BYPASS_EN),
    .BYPASS_BASE (BYPASS_BASE),
    .BYPASS_LOG2 (BYPASS_LOG2)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .winCfg    (winCfg),
    .stb       (stb),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspBypass (rspBypass),
    .rspWin    (rspWin),
    .rspAddr   (rspAddr)
  );
endmodule

// File: tb/xlat_top_bench.sv
`timescale 1ns/1ps
module xlat_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgWin = '0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        rspValid, rspHit, rspBypass;
  logic [1:0]  rspWin;
  logic [63:0] rspAddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xlat_top #(
    .NUM_WIN(4), .ADDR_W(64), .BYPASS_EN(1'b1),
    .BYPASS_BASE(64'h0000_8000_0000_0000), .BYPASS_LOG2(32)
  ) u_xlat_top (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgWin(cfgWin), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspBypass(rspBypass), .rspWin(rspWin),
    .rspAddr(rspAddr)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cfgWrite(input int win, input int sel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgWin = 2'(win); cfgSel = 3'(sel); cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input int win, input int sel, input logic [31:0] exp, input string what);
    @(negedge clk);
    cfgWin = 2'(win); cfgSel = 3'(sel);
    #1 chk(64'(cfgRdata), 64'(exp), what);
  endtask

  task automatic lookup(input logic [63:0] addr, input logic expHit, input logic expByp,
                        input int expWin, input logic [63:0] expAddr, input string what);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    chk(64'(rspValid), 64'd1, {what, " valid"});
    chk(64'(rspHit), 64'(expHit), {what, " hit"});
    chk(64'(rspBypass), 64'(expByp), {what, " bypass"});
    chk(64'(rspWin), 64'(expWin), {what, " win"});
    chk(rspAddr, expAddr, {what, " addr"});
  endtask

  task automatic t_reset;
    chk(64'(rspValid), 0, "R1 reset valid");
    chk(64'(rspHit), 0, "R1 reset hit");
    chk(64'(rspBypass), 0, "R1 reset bypass");
    chk(rspAddr, 0, "R1 reset addr");
    cfgRead(0, 4, 32'h0, "R8 reset attr");
  endtask

  task automatic t_basic;
    cfgWrite(0, 0, 32'h80);
    cfgWrite(0, 2, 32'h10);
    cfgWrite(0, 4, 32'h8000_000B);
    cfgRead(0, 2, 32'h10, "R8 base readback");
    lookup(64'h10123, 1, 0, 0, 64'h80123, "R4 mid window");
    lookup(64'h10000, 1, 0, 0, 64'h80000, "R4 lower edge");
  endtask

  task automatic t_bounds;
    lookup(64'h10FFF, 1, 0, 0, 64'h80FFF, "R3 last byte");
    lookup(64'h11000, 0, 0, 0, 64'h11000, "R3 R6 one past limit");
    lookup(64'hFFFF, 0, 0, 0, 64'hFFFF, "R6 below base");
    cfgWrite(1, 0, 32'h7);
    cfgWrite(1, 2, 32'h200);
    cfgWrite(1, 4, 32'h8000_000C);
    lookup(64'h201FFF, 1, 0, 1, 64'h8FFF, "R3 exp12 last");
    lookup(64'h202000, 0, 0, 0, 64'h202000, "R3 exp12 past");
  endtask

  task automatic t_disabled;
    cfgWrite(2, 0, 32'h1);
    cfgWrite(2, 2, 32'h300);
    cfgWrite(2, 4, 32'h0000_000C);
    lookup(64'h300010, 0, 0, 0, 64'h300010, "R2 disabled miss");
    cfgWrite(2, 4, 32'h8000_000C);
    lookup(64'h300010, 1, 0, 2, 64'h1010, "R2 enabled hit");
  endtask

  task automatic t_overlap;
    cfgWrite(2, 2, 32'h201);
    cfgWrite(2, 4, 32'h8000_000B);
    lookup(64'h201800, 1, 0, 1, 64'h8800, "R5 lowest wins");
    cfgWrite(1, 4, 32'h0000_000C);
    lookup(64'h201800, 1, 0, 2, 64'h1800, "R5 next window");
  endtask

  task automatic t_ext;
    cfgWrite(0, 1, 32'hFFFF_FFFF);
    cfgWrite(0, 3, 32'h1234_5678);
    cfgRead(0, 1, 32'hFFFF_FFFF, "R9 xlat ext stored");
    cfgRead(0, 3, 32'h1234_5678, "R9 base ext stored");
    lookup(64'h10123, 1, 0, 0, 64'h80123, "R9 ext ignored");
  endtask

  task automatic t_attr;
    cfgWrite(0, 4, 32'hA0F5_500B);
    cfgRead(0, 4, 32'hA0F5_500B, "R10 attr stored");
    lookup(64'h10123, 1, 0, 0, 64'h80123, "R10 hit unchanged");
    lookup(64'h11000, 0, 0, 0, 64'h11000, "R10 size unchanged");
    cfgWrite(0, 5, 32'hDEAD_BEEF);
    cfgRead(0, 5, 32'h0, "R8 unused selector");
  endtask

  task automatic t_whole;
    cfgWrite(3, 0, 32'h1);
    cfgWrite(3, 2, 32'h0);
    cfgWrite(3, 4, 32'h8000_003F);
    lookup(64'hFFFF_FFFF_FFFF_FFF0, 1, 0, 3, 64'h0FF0, "R3 R4 top wraps");
    lookup(64'h5000, 1, 0, 3, 64'h6000, "R3 whole space low");
  endtask

  task automatic t_bypass;
    lookup(64'h0000_8000_0000_1234, 0, 1, 0, 64'h0000_8000_0000_1234, "R7 bypass wins");
    lookup(64'h0000_8001_0000_0000, 1, 0, 3, 64'h0000_8001_0000_1000, "R7 past bypass");
  endtask

  task automatic t_sameCycle;
    @(negedge clk);
    cfgWe = 1'b1; cfgWin = 2'd0; cfgSel = 3'd4; cfgWdata = 32'h0000_000B;
    reqValid = 1'b1; reqAddr = 64'h10123;
    @(negedge clk);
    cfgWe = 1'b0;
    reqAddr = 64'h10123;
    chk(64'(rspHit), 1, "R11 old config hit");
    chk(64'(rspWin), 0, "R11 old config win");
    chk(rspAddr, 64'h80123, "R11 old config addr");
    @(negedge clk);
    reqValid = 1'b0;
    chk(64'(rspValid), 1, "R1 back to back valid");
    chk(64'(rspWin), 3, "R11 new config win");
    chk(rspAddr, 64'h11123, "R11 new config addr");
    @(negedge clk);
    chk(64'(rspValid), 0, "R1 idle drops valid");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_bounds();
    t_disabled();
    t_overlap();
    t_ext();
    t_attr();
    t_whole();
    t_bypass();
    t_sameCycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule